// File: doc/BRIEF.md
# Legacy INTx Pulse Interrupt Aggregator

This block merges the four PCIe legacy virtual-wire interrupts onto one interrupt output that is a single-cycle pulse. An upstream decoder hands it one message per cycle. Each message carries the interrupt number (0 = INTA through 3 = INTD) and a flag that says whether the message is an assert or a deassert. Each line has a sticky pending bit and an enable bit. Software uses a small register port to enable lines, read the pending bits, clear them by writing ones, and signal end-of-interrupt (EOI).

The pulse line does not keep a level, so the block imitates one. In normal mode, an EOI write fires a new pulse whenever an enabled line is still pending. The `DEGRADED` parameter selects a second mode. In that mode EOI does nothing, and every assert or deassert message on an enabled line fires its own pulse. A three-state pulse machine (`ST_IDLE`, `ST_FIRE`, `ST_HOLD`) keeps each pulse exactly one cycle wide. A request that arrives during a pulse is held, then issued after one low cycle.

Pulse machine transitions:
- `ST_IDLE` → `ST_FIRE` when a request arrives.
- `ST_FIRE` → `ST_HOLD` when another request arrives during the pulse.
- `ST_FIRE` → `ST_IDLE` otherwise.
- `ST_HOLD` → `ST_FIRE` always.

Top module: `intx_pulse_agg`

## Requirements
- R1: After reset, `irq_pulse` is low and the enable and pending registers both read as zero.
- R2: `irq_pulse` is never high for two cycles in a row. A request that arrives while a pulse is high produces a second pulse two cycles after the first, with one low cycle between them.
- R3: An assert message for interrupt number n (0 = INTA … 3 = INTD) sets pending bit 3−n. The bit order is reversed relative to the interrupt number.
- R4: In normal mode, a pulse appears in the cycle after any enabled pending bit goes from clear to set. An assert on a line that is already pending fires no pulse. A deassert changes neither the pending bits nor the output.
- R5: A message on a disabled line still sets its pending bit but fires no pulse. Writing an enable that exposes an already-pending bit fires a pulse.
- R6: In normal mode, a write to offset 0x10 (EOI) fires a pulse if any enabled pending bit is set. Otherwise it fires nothing.
- R7: With `DEGRADED`=1, an EOI write has no effect. Every assert message and every deassert message on an enabled line sets the line's pending bit and fires one pulse.
- R8: Writing offset 0x700 clears each pending bit whose data bit is 1 and leaves bits written as 0 unchanged. If a set and a clear hit the same bit in one cycle, the set wins.
- R9: The read port returns the enable register at offset 0x100 in bits [3:0] and the pending bits at offset 0x500. Every other offset, including 0x10 and 0x700, reads as zero.
- R10: Requests that arrive in the same cycle, such as an EOI write together with a new assert, produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message strobe from the message decoder |
| msg_assert | input | 1 | 1 = assert message, 0 = deassert message |
| msg_num | input | 2 | Interrupt number, 0 = INTA … 3 = INTD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | Single-cycle interrupt pulse to the interrupt controller |

## Verification
Pending bits, enable bits and the pulse state all change on the clock edge that captures a message or a write. Each of these results is therefore due one edge after its stimulus. The bench drives inputs just after a falling edge and samples `irq_pulse` and the read data at the next falling edge. It then checks the following falling edge to confirm that the pulse has ended. Read data comes from a combinational path, so the bench sets `rd_addr` and samples it a moment later within the same low phase. A deferred pulse lands two edges after the request that caused it, and the back-to-back check samples three falling edges in a row to see high, low, high.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } pulse_st_e;

    localparam logic [11:0] OFS_EOI  = 12'h010;
    localparam logic [11:0] OFS_EN   = 12'h100;
    localparam logic [11:0] OFS_STAT = 12'h500;
    localparam logic [11:0] OFS_CLR  = 12'h700;
endpackage

// File: rtl/intx_agg_regs.sv
module intx_agg_regs #(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NUM_LINES-1:0] status_q,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] en_next,
    output logic [NUM_LINES-1:0] clr_mask,
    output logic                 eoi_wr,
    output logic [DATA_W-1:0]    rd_data
);
    import intx_agg_pkg::*;

    logic en_wr;

    assign en_wr    = wr_en && (wr_addr == ADDR_W'(OFS_EN));
    assign eoi_wr   = wr_en && (wr_addr == ADDR_W'(OFS_EOI));
    assign clr_mask = (wr_en && (wr_addr == ADDR_W'(OFS_CLR))) ? wr_data[NUM_LINES-1:0] : '0;
    assign en_next  = en_wr ? wr_data[NUM_LINES-1:0] : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_EN))
            rd_data[NUM_LINES-1:0] = en_q;
        else if (rd_addr == ADDR_W'(OFS_STAT))
            rd_data[NUM_LINES-1:0] = status_q;
    end
endmodule

// File: rtl/intx_agg_status.sv
module intx_agg_status #(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2,
    parameter bit DEGRADED  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic                 msg_assert,
    input  logic [LINE_W-1:0]    msg_num,
    input  logic [NUM_LINES-1:0] clr_mask,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] en_next,
    input  logic                 eoi_wr,
    output logic [NUM_LINES-1:0] status_q,
    output logic [NUM_LINES-1:0] set_mask,
    output logic                 fire_req
);
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] status_next;
    logic [NUM_LINES-1:0] pend_cur;
    logic [NUM_LINES-1:0] pend_next;
    logic                 newly_pending;

    // Bit i of the pending vector belongs to interrupt number NUM_LINES-1-i.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign hit[i] = msg_valid && (msg_num == LINE_W'(NUM_LINES - 1 - i));
        if (DEGRADED) begin : g_deg
            assign set_mask[i] = hit[i];
        end else begin : g_norm
            assign set_mask[i] = hit[i] && msg_assert;
        end
    end

    // Set has priority over a same-cycle clear.
    assign status_next   = (status_q & ~clr_mask) | set_mask;
    assign pend_cur      = status_q & en_q;
    assign pend_next     = status_next & en_next;
    assign newly_pending = |(pend_next & ~pend_cur);

    if (DEGRADED) begin : g_req_deg
        assign fire_req = newly_pending || (|(set_mask & en_next));
    end else begin : g_req_norm
        assign fire_req = newly_pending || (eoi_wr && (|pend_next));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_next;
    end
endmodule

// File: rtl/intx_agg_fsm.sv
module intx_agg_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    output logic irq_o
);
    import intx_agg_pkg::*;

    pulse_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire_req) state_d = ST_FIRE;
            ST_FIRE: state_d = fire_req ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = ST_FIRE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/intx_pulse_agg.sv
module intx_pulse_agg #(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter bit DEGRADED  = 1'b0,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic              msg_assert,
    input  logic [LINE_W-1:0] msg_num,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse
);
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] set_mask;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] en_next;
    logic [NUM_LINES-1:0] clr_mask;
    logic                 eoi_wr;
    logic                 fire_req;

    intx_agg_regs #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .status_q(status_q),
        .en_q(en_q), .en_next(en_next), .clr_mask(clr_mask),
        .eoi_wr(eoi_wr), .rd_data(rd_data)
    );

    intx_agg_status #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .DEGRADED(DEGRADED)
    ) status_i (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_assert(msg_assert), .msg_num(msg_num),
        .clr_mask(clr_mask), .en_q(en_q), .en_next(en_next), .eoi_wr(eoi_wr),
        .status_q(status_q), .set_mask(set_mask), .fire_req(fire_req)
    );

    intx_agg_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .fire_req(fire_req), .irq_o(irq_pulse)
    );
endmodule

// File: rtl/intx_pulse_agg_chk.sv
module intx_pulse_agg_chk #(
    parameter int NUM_LINES = 4,
    parameter bit DEGRADED  = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_pulse,
    input logic                 eoi_wr,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] set_mask,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] en_next,
    input logic [NUM_LINES-1:0] clr_mask
);
    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

    assert_sticky_unless_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=>
            ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    if (DEGRADED) begin : g_deg
        assert_every_event_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((|(set_mask & en_next)) && !irq_pulse) |=> irq_pulse);
    end else begin : g_norm
        assert_eoi_repulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_wr && (|(status_q & en_q)) && !irq_pulse) |=> irq_pulse);
    end
endmodule

bind intx_pulse_agg intx_pulse_agg_chk #(
    .NUM_LINES(NUM_LINES), .DEGRADED(DEGRADED)
) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .eoi_wr(eoi_wr),
    .status_q(status_q), .set_mask(set_mask), .en_q(en_q),
    .en_next(en_next), .clr_mask(clr_mask)
);

// File: tb/intx_pulse_agg_tb_top.sv
module intx_pulse_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_EOI  = 12'h010;
    localparam logic [11:0] A_EN   = 12'h100;
    localparam logic [11:0] A_STAT = 12'h500;
    localparam logic [11:0] A_CLR  = 12'h700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_assert = 1'b0;
    logic [1:0]  msg_num = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_n, rd_d;
    logic        irq_n, irq_d;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_pulse_agg #(.DEGRADED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_assert(msg_assert),
        .msg_num(msg_num), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_n), .irq_pulse(irq_n)
    );

    intx_pulse_agg #(.DEGRADED(1'b1)) dut_deg_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_assert(msg_assert),
        .msg_num(msg_num), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_d), .irq_pulse(irq_d)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send(input logic is_assert, input logic [1:0] num);
        msg_valid = 1'b1; msg_assert = is_assert; msg_num = num;
        cyc();
        msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] vn, output logic [31:0] vd);
        rd_addr = a;
        #1;
        vn = rd_n; vd = rd_d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] vn, vd;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 irq normal", 32'(irq_n), 0);
        chk("R1 irq degraded", 32'(irq_d), 0);
        rd(A_EN, vn, vd);   chk("R1 enable", vn, 0);  chk("R1 enable deg", vd, 0);
        rd(A_STAT, vn, vd); chk("R1 status", vn, 0);  chk("R1 status deg", vd, 0);

        // Sweep: every enable pattern against every interrupt number
        for (int e = 0; e < 16; e++) begin
            for (int n = 0; n < 4; n++) begin
                automatic int b = 3 - n;
                automatic logic eb = e[b];
                wr(A_CLR, 32'hF);
                wr(A_EN, 32'(e));
                chk("R1/R5 no pulse on enable with nothing pending", 32'(irq_n), 0);
                send(1'b1, 2'(n));
                chk("R4/R5 assert pulse normal", 32'(irq_n), 32'(eb));
                chk("R7 assert pulse degraded", 32'(irq_d), 32'(eb));
                rd(A_STAT, vn, vd);
                chk("R3 pending bit normal", vn, 32'(1) << b);
                chk("R3 pending bit degraded", vd, 32'(1) << b);
                cyc();
                chk("R2 pulse ends normal", 32'(irq_n), 0);
                chk("R2 pulse ends degraded", 32'(irq_d), 0);
                send(1'b1, 2'(n));
                chk("R4 re-assert of pending line silent", 32'(irq_n), 0);
                chk("R7 re-assert pulses degraded", 32'(irq_d), 32'(eb));
                cyc(); cyc();
                send(1'b0, 2'(n));
                chk("R4 deassert silent normal", 32'(irq_n), 0);
                chk("R7 deassert pulse degraded", 32'(irq_d), 32'(eb));
                rd(A_STAT, vn, vd);
                chk("R4 deassert keeps pending", vn, 32'(1) << b);
                cyc(); cyc();
                wr(A_EOI, 32'h0);
                chk("R6 EOI re-pulse normal", 32'(irq_n), 32'(eb));
                chk("R7 EOI ignored degraded", 32'(irq_d), 0);
                rd(A_EN, vn, vd);
                chk("R9 enable readback", vn, 32'(e));
                cyc(); cyc();
            end
        end

        // R6: EOI with nothing pending
        wr(A_CLR, 32'hF); wr(A_EN, 32'hF); cyc();
        wr(A_EOI, 32'h0);
        chk("R6 EOI idle no pulse", 32'(irq_n), 0);

        // R5: enabling a pending line fires
        wr(A_EN, 32'h0);
        send(1'b1, 2'd3);
        chk("R5 disabled no pulse", 32'(irq_n), 0);
        rd(A_STAT, vn, vd); chk("R5 disabled still pending", vn, 32'h1);
        cyc();
        wr(A_EN, 32'h1);
        chk("R5 enable exposes pending", 32'(irq_n), 1);
        cyc(); cyc();

        // R8: write of zero to clear register leaves pending bits unchanged
        send(1'b1, 2'd0); cyc(); cyc();
        wr(A_CLR, 32'h0);
        rd(A_STAT, vn, vd); chk("R8 clear of zero no effect", vn, 32'h9);
        wr(A_CLR, 32'h8);
        rd(A_STAT, vn, vd); chk("R8 clear one bit", vn, 32'h1);
        // R8: set wins over a same-cycle clear (INTB -> bit 2)
        send(1'b1, 2'd1); cyc(); cyc();
        msg_valid = 1'b1; msg_assert = 1'b1; msg_num = 2'd1;
        wr(A_CLR, 32'h4);
        msg_valid = 1'b0;
        rd(A_STAT, vn, vd); chk("R8 set wins over clear", vn, 32'h5);

        // R9: other offsets read zero
        rd(A_CLR, vn, vd); chk("R9 clear offset reads zero", vn, 0);
        rd(A_EOI, vn, vd); chk("R9 EOI offset reads zero", vn, 0);
        rd(12'h004, vn, vd); chk("R9 unmapped reads zero", vn, 0);

        // R2: back-to-back requests split by one low cycle
        wr(A_CLR, 32'hF); wr(A_EN, 32'hF); cyc();
        send(1'b1, 2'd0);
        chk("R2 first pulse", 32'(irq_n), 1);
        send(1'b1, 2'd1);
        chk("R2 gap cycle", 32'(irq_n), 0);
        cyc();
        chk("R2 deferred pulse", 32'(irq_n), 1);
        cyc();
        chk("R2 back to idle", 32'(irq_n), 0);
        cyc();

        // R10: EOI plus new assert in one cycle -> one pulse
        msg_valid = 1'b1; msg_assert = 1'b1; msg_num = 2'd2;
        wr(A_EOI, 32'h0);
        msg_valid = 1'b0;
        chk("R10 merged pulse", 32'(irq_n), 1);
        cyc();
        chk("R10 merged pulse ends", 32'(irq_n), 0);
        cyc();
        chk("R10 no second pulse", 32'(irq_n), 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule